// File: doc/BRIEF.md
# Prefix Displacement Extension Unit

This unit sits between the fetch buffer and the decoder of a processor whose instructions are all 16 bits wide. Such short instructions leave little room for constants and memory offsets. A program therefore places a prefix instruction in front of any instruction whose constant or offset does not fit. The prefix carries an 8-bit payload. The unit stores the payload and then places it as the upper bits directly above the short operand field of the next instruction. The result is a wider value built by joining the two fields, not by sign-extending the short field.

Each instruction accepted at the input produces one registered result on the following cycle. A prefix produces a bubble slot that performs no operation. Any other instruction produces a valid slot that carries the instruction word, a 32-bit operand, the 2-bit base-pair select and a flag that says whether an extension was applied. A stored payload is used by exactly one instruction. A flush or branch redirect discards it.

Instruction layout. The opcode is in bits [15:12]: 4'hF is the prefix, 4'h8 is a load, 4'h9 is a store and 4'h2 is a short immediate. The prefix payload is in bits [7:0]. A load or store keeps its base select in bits [7:6] and its offset in bits [5:0]. A short immediate keeps its value in bits [3:0].

Top module: `pdx_unit`

## Requirements
- R1: While `rst` is high, every output is zero on the next clock edge, and no extension is pending afterwards.
- R2: An accepted prefix (opcode 4'hF) gives `out_bubble`=1, `out_valid`=0, `out_ext`=0 and operand 0 one cycle later, with `out_instr` equal to the prefix word. Its bits [7:0] become the pending payload.
- R3: A load or store (opcode 4'h8 or 4'h9) that follows a pending payload P yields `out_operand` = zero-extended {P, bits[5:0]} (14 bits) and `out_ext`=1.
- R4: A load or store with no pending payload yields `out_operand` = zero-extended bits[5:0] and `out_ext`=0.
- R5: For a load or store, `out_base` equals bits [7:6] (values 0 to 3 select base pairs 0 to 3). For every other slot it is 0.
- R6: A short immediate (opcode 4'h2) that follows a pending payload P yields zero-extended {P, bits[3:0]} and `out_ext`=1. For example, P=8'hC1 with field 4'h4 gives 32'h0000_0C14.
- R7: A short immediate with no pending payload yields bits[3:0] sign-extended to 32 bits, with `out_ext`=0.
- R8: A pending payload is consumed by the next accepted non-prefix instruction of any kind. Any other opcode yields operand 0 and `out_ext`=0, and the instruction after it is not extended.
- R9: When `flush` is high, the input is ignored, no valid or bubble slot is produced on the next cycle, and any pending payload is discarded.
- R10: A prefix that follows a pending payload replaces it. Only the newest payload is used.
- R11: A cycle with `in_valid` low and no flush produces an all-zero slot and leaves a pending payload in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Flush or branch redirect; discards the input and the pending payload |
| in_valid | input | 1 | Instruction word present |
| in_instr | input | 16 | Instruction word from the fetch buffer |
| out_valid | output | 1 | Non-prefix instruction slot |
| out_bubble | output | 1 | Prefix slot with no operation |
| out_instr | output | 16 | Instruction word forwarded to the decoder |
| out_operand | output | 32 | Formed operand or offset |
| out_base | output | 2 | Base-pair select of a load or store |
| out_ext | output | 1 | Operand was widened by a prefix payload |

## Verification
The bench builds the unit with its default widths: an 8-bit payload, a 6-bit memory offset and a 4-bit immediate field. With these widths both extended sizes occur, 14 bits for memory offsets and 12 bits for immediates, as does the sign bit of the short immediate. A directed prologue covers the worked 12-bit example, prefix chains, idle gaps and flushes landing on a pending payload. Several thousand random cycles, weighted toward prefixes, then exercise every ordering of prefix, memory, immediate, other-opcode, idle and flush slots against a behavioural model.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_IMM    = 4'h2,
    OPC_LOAD   = 4'h8,
    OPC_STORE  = 4'h9,
    OPC_PREFIX = 4'hF
  } opc_e;

  function automatic logic is_mem_opc(input logic [OPC_W-1:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_STORE);
  endfunction
endpackage

// File: rtl/pdx_ext_reg.sv
module pdx_ext_reg #(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 load_en,
  input  logic [PAYLOAD_W-1:0] payload_in,
  input  logic                 consume,
  output logic                 pending,
  output logic [PAYLOAD_W-1:0] payload
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pending <= 1'b0;
      payload <= '0;
    end else if (load_en) begin
      pending <= 1'b1;
      payload <= payload_in;
    end else if (consume) begin
      pending <= 1'b0;
      payload <= '0;
    end
  end
endmodule

// File: rtl/pdx_operand_form.sv
module pdx_operand_form
  import pdx_pkg::*;
#(
  parameter int PAYLOAD_W = 8,
  parameter int OFF_W     = 6,
  parameter int IMM_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic                 pending,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [DATA_W-1:0]    operand,
  output logic [1:0]           base,
  output logic                 ext
);
  localparam int MEXT_W = PAYLOAD_W + OFF_W;
  localparam int IEXT_W = PAYLOAD_W + IMM_W;

  logic [OPC_W-1:0]  opc;
  logic [OFF_W-1:0]  off;
  logic [IMM_W-1:0]  imm;
  logic [MEXT_W-1:0] mem_wide;
  logic [IEXT_W-1:0] imm_wide;

  assign opc      = instr[INSTR_W-1 -: OPC_W];
  assign off      = instr[OFF_W-1:0];
  assign imm      = instr[IMM_W-1:0];
  assign mem_wide = {payload, off};
  assign imm_wide = {payload, imm};

  always_comb begin
    operand = '0;
    base    = '0;
    ext     = 1'b0;
    if (is_mem_opc(opc)) begin
      base = instr[OFF_W+1:OFF_W];
      ext  = pending;
      if (pending) operand = {{(DATA_W-MEXT_W){1'b0}}, mem_wide};
      else         operand = {{(DATA_W-OFF_W){1'b0}}, off};
    end else if (opc == OPC_IMM) begin
      ext = pending;
      if (pending) operand = {{(DATA_W-IEXT_W){1'b0}}, imm_wide};
      else         operand = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end
  end
endmodule

// File: rtl/pdx_unit.sv
module pdx_unit
  import pdx_pkg::*;
#(
  parameter int PAYLOAD_W = 8,
  parameter int OFF_W     = 6,
  parameter int IMM_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               in_valid,
  input  logic [15:0]        in_instr,
  output logic               out_valid,
  output logic               out_bubble,
  output logic [15:0]        out_instr,
  output logic [DATA_W-1:0]  out_operand,
  output logic [1:0]         out_base,
  output logic               out_ext
);
  logic                 accept, is_prefix;
  logic                 pending;
  logic [PAYLOAD_W-1:0] payload;
  logic [DATA_W-1:0]    f_operand;
  logic [1:0]           f_base;
  logic                 f_ext;

  assign accept    = in_valid && !flush;
  assign is_prefix = (in_instr[INSTR_W-1 -: OPC_W] == OPC_PREFIX);

  pdx_ext_reg #(.PAYLOAD_W(PAYLOAD_W)) u_ext_reg (
    .clk(clk), .rst(rst), .flush(flush),
    .load_en(accept && is_prefix),
    .payload_in(in_instr[PAYLOAD_W-1:0]),
    .consume(accept && !is_prefix),
    .pending(pending), .payload(payload)
  );

  pdx_operand_form #(
    .PAYLOAD_W(PAYLOAD_W), .OFF_W(OFF_W), .IMM_W(IMM_W), .DATA_W(DATA_W)
  ) u_form (
    .instr(in_instr), .pending(pending), .payload(payload),
    .operand(f_operand), .base(f_base), .ext(f_ext)
  );

  always_ff @(posedge clk) begin
    if (rst || !accept) begin
      out_valid   <= 1'b0;
      out_bubble  <= 1'b0;
      out_instr   <= '0;
      out_operand <= '0;
      out_base    <= '0;
      out_ext     <= 1'b0;
    end else begin
      out_valid   <= !is_prefix;
      out_bubble  <= is_prefix;
      out_instr   <= in_instr;
      out_operand <= is_prefix ? '0 : f_operand;
      out_base    <= is_prefix ? 2'b00 : f_base;
      out_ext     <= !is_prefix && f_ext;
    end
  end

  // R2: an accepted prefix leaves a payload pending
  assert_prefix_arms_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && is_prefix) |=> pending);

  // R3: an extended slot needs a payload that was pending when it entered
  assert_ext_needs_prefix_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_ext) |-> $past(pending));

  // R8: a non-prefix instruction uses up the payload
  assert_single_use_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_prefix) |=> !pending);

  // R9: a flush yields an empty slot and drops the payload
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && !out_bubble && !pending));

  // R11: an idle cycle keeps the payload
  assert_idle_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flush) |=> $stable(pending));
endmodule

// File: tb/test_pdx_unit.sv
module test_pdx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_instr = '0;
  logic        out_valid, out_bubble, out_ext;
  logic [15:0] out_instr;
  logic [31:0] out_operand;
  logic [1:0]  out_base;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model state
  bit          m_pend = 0;
  logic [7:0]  m_pay = '0;
  bit          e_valid, e_bubble, e_ext;
  logic [15:0] e_instr;
  logic [31:0] e_operand;
  logic [1:0]  e_base;
  string       e_tag = "R1";

  pdx_unit i_pdx_unit (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_instr(in_instr), .out_valid(out_valid), .out_bubble(out_bubble),
    .out_instr(out_instr), .out_operand(out_operand), .out_base(out_base),
    .out_ext(out_ext)
  );

  always #5 clk = ~clk;

  task automatic compare();
    total++;
    if (out_valid !== e_valid || out_bubble !== e_bubble || out_ext !== e_ext ||
        out_instr !== e_instr || out_operand !== e_operand || out_base !== e_base) begin
      bad++;
      $display("FAIL %s: got v=%0b b=%0b x=%0b i=%h op=%h base=%0d exp v=%0b b=%0b x=%0b i=%h op=%h base=%0d",
               e_tag, out_valid, out_bubble, out_ext, out_instr, out_operand, out_base,
               e_valid, e_bubble, e_ext, e_instr, e_operand, e_base);
    end
  endtask

  // apply one input cycle; expectation is compared at the next negedge
  task automatic step(input bit r, input bit v, input logic [15:0] ins, input bit fl);
    rst = r; in_valid = v; in_instr = ins; flush = fl;
    e_valid = 0; e_bubble = 0; e_ext = 0; e_instr = '0; e_operand = '0; e_base = '0;
    if (r) begin
      e_tag = "R1"; m_pend = 0; m_pay = '0;
    end else if (fl) begin
      e_tag = "R9"; m_pend = 0;
    end else if (!v) begin
      e_tag = "R11";
    end else if (ins[15:12] == 4'hF) begin
      e_tag = m_pend ? "R10" : "R2";
      e_bubble = 1; e_instr = ins; m_pend = 1; m_pay = ins[7:0];
    end else begin
      e_valid = 1; e_instr = ins;
      if (ins[15:12] == 4'h8 || ins[15:12] == 4'h9) begin
        e_base = ins[7:6];
        if (m_pend) begin
          e_tag = "R3,R5"; e_ext = 1;
          e_operand = 32'(m_pay) * 64 + 32'(ins[5:0]);
        end else begin
          e_tag = "R4,R5"; e_operand = 32'(ins[5:0]);
        end
      end else if (ins[15:12] == 4'h2) begin
        if (m_pend) begin
          e_tag = "R6"; e_ext = 1;
          e_operand = 32'(m_pay) * 16 + 32'(ins[3:0]);
        end else begin
          e_tag = "R7";
          e_operand = ins[3] ? (32'(ins[3:0]) - 32'd16) : 32'(ins[3:0]);
        end
      end else begin
        e_tag = "R8";
      end
      m_pend = 0;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got no finish, exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    compare();                              // R1 reset state
    step(1, 1, 16'hF0AA, 0);               // R1 reset ignores input
    step(0, 1, 16'h2004, 0);               // R7 positive immediate
    step(0, 1, 16'h200C, 0);               // R7 negative immediate
    step(0, 1, 16'hF0C1, 0);               // R2 prefix
    step(0, 1, 16'h2004, 0);               // R6 -> 0xC14
    step(0, 1, 16'h2004, 0);               // R8 single use
    step(0, 1, 16'h80FF, 0);               // R4,R5 base 3
    step(0, 1, 16'hF033, 0);
    step(0, 1, 16'hF0E7, 0);               // R10 replace
    step(0, 0, 16'h0000, 0);               // R11 gap keeps payload
    step(0, 1, 16'h9045, 0);               // R3,R5 base 1
    step(0, 1, 16'hF012, 0);
    step(0, 1, 16'h5123, 0);               // R8 other opcode consumes
    step(0, 1, 16'h8001, 0);               // R4 not extended
    step(0, 1, 16'hF0FF, 0);
    step(0, 1, 16'h8081, 1);               // R9 flush
    step(0, 1, 16'h8081, 0);               // R4 after flush
    step(0, 1, 16'hF0AB, 0);
    step(1, 0, 16'h0000, 0);               // R1 reset drops payload
    step(0, 1, 16'h2007, 0);               // R7 after reset
    for (int k = 0; k < 6000; k++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] w = 16'($urandom);
      case (sel)
        0, 1, 2: w[15:12] = 4'hF;
        3:       w[15:12] = 4'h8;
        4:       w[15:12] = 4'h9;
        5, 6:    w[15:12] = 4'h2;
        default: ;
      endcase
      step(0, $urandom_range(0, 7) != 0, w, $urandom_range(0, 15) == 0);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule